// File: doc/BRIEF.md
# Periodic Fiber Packet Transmit Framer

This block assembles outgoing packets for a single serial fiber channel. A programmable timer opens a new packet slot every `period_len` clock cycles. Within each slot the block walks a word index from zero upward and presents it on `rd_idx` to an external payload source. That source returns the matching 32-bit word exactly one cycle later on `rd_data`. The block then drives a transmit stream made of a valid flag, the data word and an end-of-frame marker. The marker flags the last word of the packet.

Two qualifying inputs gate the transfer: the channel enable and the transmitter-ready flag. While either one is low the packet pauses at its current index. It continues from that index once both are high again. The word count is sampled every cycle. A count of zero produces a slot with no traffic.

Top module: `fiber_tx_framer`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `rd_idx` = 0, `tx_valid` = 0, `tx_eof` = 0 and `tx_data` = 0, and the period timer is cleared to zero.
- R2: When `tx_valid` is 1, `tx_data` equals the `rd_data` word that the source returned for the index presented on `rd_idx` in the previous cycle.
- R3: A word is fetched in a cycle when both gates are high, no period starts in that cycle and `rd_idx` < `word_count`. `rd_idx` then rises by exactly one at the next edge, and `tx_valid` is 1 in the next cycle.
- R4: Once `rd_idx` reaches `word_count`, it holds that value and `tx_valid` stays 0 until the next period start.
- R5: If `chan_en` or `tx_rdy` is 0 in a cycle that is not a period start, `rd_idx` keeps its value and `tx_valid` is 0 in the next cycle. Fetching resumes from the same index when both gates return to 1.
- R6: `tx_eof` is 1 only in the cycle that carries the word fetched at index `word_count`-1, and it is never 1 without `tx_valid`.
- R7: A period start occurs in the first cycle after reset, and again every max(`period_len`,1) cycles. In a start cycle nothing is fetched, and `rd_idx` is 0 in the cycle after.
- R8: With `word_count` = 0, a period produces no valid word and no end-of-frame.
- R9: When `tx_valid` is 0, `tx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable gate |
| tx_rdy | input | 1 | Transmitter ready gate |
| period_len | input | 16 | Cycles between packet starts |
| word_count | input | 9 | Words per packet |
| rd_data | input | 32 | Payload word, one cycle after its index |
| rd_idx | output | 9 | Payload read index |
| tx_valid | output | 1 | Transmit word valid |
| tx_data | output | 32 | Transmit word |
| tx_eof | output | 1 | Last word of packet |

## Verification
The hardest case to reach is a gate drop that lands exactly on the last word of a packet, or right beside a period start. It is especially hard when the period is shorter than the packet, so that a start cuts off a packet still in flight. The bench gets there in two ways. Directed segments use short periods, a long word count and a zero period. A long seeded random run toggles both gates independently and now and then changes the period and the word count. A cycle model in the bench predicts every output in every cycle.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
    localparam int FTX_DATA_W = 32;
    localparam int FTX_CNT_W  = 9;
    localparam int FTX_PER_W  = 16;

    // control for one fetched beat, travels alongside the read latency
    typedef struct packed {
        logic fetch;
        logic last;
    } ftx_ctl_t;

    typedef enum logic [1:0] {
        IDX_RUN   = 2'd0,
        IDX_STALL = 2'd1,
        IDX_DONE  = 2'd2
    } ftx_idx_state_e;
endpackage

// File: rtl/ftx_period_timer.sv
module ftx_period_timer #(
    parameter int PER_W = ftx_pkg::FTX_PER_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] period_len,
    output logic             start_o
);
    logic [PER_W-1:0] tmr_q;
    logic [PER_W-1:0] reload;

    assign start_o = (tmr_q == '0);
    assign reload  = (period_len == '0) ? '0 : period_len - 1'b1;

    always_ff @(posedge clk) begin
        if (rst)          tmr_q <= '0;
        else if (start_o) tmr_q <= reload;
        else              tmr_q <= tmr_q - 1'b1;
    end

    // the timer only moves downward between starts
    assert_timer_down_R7: assert property (@(posedge clk) disable iff (rst)
        (tmr_q != '0) |=> (tmr_q == $past(tmr_q) - 1'b1));
endmodule

// File: rtl/ftx_index_ctr.sv
module ftx_index_ctr
    import ftx_pkg::*;
#(
    parameter int CNT_W = FTX_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             gate_i,
    input  logic [CNT_W-1:0] word_count,
    output logic [CNT_W-1:0] idx_o,
    output ftx_ctl_t         ctl_o
);
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W:0]   idx_nxt_wide;
    ftx_idx_state_e   st;

    assign idx_nxt_wide = {1'b0, idx_q} + 1'b1;

    always_comb begin
        if (idx_q >= word_count) st = IDX_DONE;
        else if (!gate_i)        st = IDX_STALL;
        else                     st = IDX_RUN;
    end

    always_comb begin
        ctl_o.fetch = !start_i && (st == IDX_RUN);
        ctl_o.last  = ctl_o.fetch && (idx_nxt_wide == {1'b0, word_count});
    end

    always_ff @(posedge clk) begin
        if (rst)              idx_q <= '0;
        else if (start_i)     idx_q <= '0;
        else if (ctl_o.fetch) idx_q <= idx_nxt_wide[CNT_W-1:0];
    end

    assign idx_o = idx_q;

    assert_start_zero_R7: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (idx_q == '0));
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !gate_i) |=> $stable(idx_q));
    assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
        (!start_i && (idx_q < word_count) && gate_i) |=> (idx_q == $past(idx_q) + 1'b1));
    assert_done_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!start_i && (idx_q >= word_count)) |=> $stable(idx_q));
endmodule

// File: rtl/ftx_beat_align.sv
module ftx_beat_align
    import ftx_pkg::*;
#(
    parameter int DATA_W = FTX_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ftx_ctl_t          ctl_i,
    input  logic [DATA_W-1:0] rd_data,
    output logic              tx_valid,
    output logic              tx_eof,
    output logic [DATA_W-1:0] tx_data
);
    ftx_ctl_t ctl_q;

    // delay control by the source read latency of one cycle
    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_i;
    end

    assign tx_valid = ctl_q.fetch;
    assign tx_eof   = ctl_q.fetch && ctl_q.last;
    assign tx_data  = ctl_q.fetch ? rd_data : '0;

    assert_eof_valid_R6: assert property (@(posedge clk) disable iff (rst)
        tx_eof |-> tx_valid);
    assert_valid_follows_fetch_R3: assert property (@(posedge clk) disable iff (rst)
        ctl_i.fetch |=> tx_valid);
    assert_idle_data_R9: assert property (@(posedge clk) disable iff (rst)
        !tx_valid |-> (tx_data == '0));
endmodule

// File: rtl/fiber_tx_framer.sv
module fiber_tx_framer
    import ftx_pkg::*;
#(
    parameter int DATA_W = FTX_DATA_W,
    parameter int CNT_W  = FTX_CNT_W,
    parameter int PER_W  = FTX_PER_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_en,
    input  logic              tx_rdy,
    input  logic [PER_W-1:0]  period_len,
    input  logic [CNT_W-1:0]  word_count,
    input  logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  rd_idx,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_eof
);
    logic     start;
    logic     gate;
    ftx_ctl_t ctl;

    assign gate = chan_en && tx_rdy;

    ftx_period_timer #(.PER_W(PER_W)) tmr_i (
        .clk        (clk),
        .rst        (rst),
        .period_len (period_len),
        .start_o    (start)
    );

    ftx_index_ctr #(.CNT_W(CNT_W)) idx_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .gate_i     (gate),
        .word_count (word_count),
        .idx_o      (rd_idx),
        .ctl_o      (ctl)
    );

    ftx_beat_align #(.DATA_W(DATA_W)) aln_i (
        .clk      (clk),
        .rst      (rst),
        .ctl_i    (ctl),
        .rd_data  (rd_data),
        .tx_valid (tx_valid),
        .tx_eof   (tx_eof),
        .tx_data  (tx_data)
    );

    assert_zero_count_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (word_count == '0) |=> !ctl_q_eof_guard(tx_eof, $past(rd_idx), $past(word_count)));

    function automatic logic ctl_q_eof_guard(logic eof, logic [CNT_W-1:0] pidx,
                                            logic [CNT_W-1:0] pcnt);
        return eof && (pidx >= pcnt);
    endfunction
endmodule

// File: tb/fiber_tx_framer_tb_top.sv
module fiber_tx_framer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYC    = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic        chan_en, tx_rdy;
    logic [15:0] period_len;
    logic [8:0]  word_count;
    logic [31:0] rd_data;
    logic [8:0]  rd_idx;
    logic        tx_valid, tx_eof;
    logic [31:0] tx_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // cycle model state
    logic [15:0] m_tim;
    logic [8:0]  m_idx, m_didx;
    logic        m_vq, m_lq, m_prev_start, m_prev_gate, m_prev_rst;
    int          valid_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    fiber_tx_framer dut_i (
        .clk(clk), .rst(rst), .chan_en(chan_en), .tx_rdy(tx_rdy),
        .period_len(period_len), .word_count(word_count), .rd_data(rd_data),
        .rd_idx(rd_idx), .tx_valid(tx_valid), .tx_data(tx_data), .tx_eof(tx_eof)
    );

    function automatic logic [31:0] word_of(logic [8:0] i);
        return 32'hC0DE_0000 + {23'd0, i} * 32'h0001_0007;
    endfunction

    // external source with one-cycle read latency
    always @(posedge clk) rd_data <= word_of(rd_idx);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= MAX_CYC) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, MAX_CYC);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic en, input logic rdy);
        logic st, fe;
        rst = r; chan_en = en; tx_rdy = rdy;
        st = (m_tim == 16'd0);
        fe = en && rdy && !st && (m_idx < word_count);
        m_prev_rst   = r;
        m_prev_start = st && !r;
        m_prev_gate  = en && rdy;
        if (r) begin
            m_tim = '0; m_idx = '0; m_vq = 1'b0; m_lq = 1'b0; m_didx = '0;
        end else begin
            m_lq   = fe && ({1'b0, m_idx} + 10'd1 == {1'b0, word_count});
            m_vq   = fe;
            m_didx = m_idx;
            m_idx  = st ? 9'd0 : (fe ? m_idx + 9'd1 : m_idx);
            m_tim  = st ? ((period_len == 16'd0) ? 16'd0 : period_len - 16'd1)
                        : m_tim - 16'd1;
        end
        @(negedge clk);
        if (tx_valid) valid_seen++;
        if (m_prev_rst) begin
            chk(rd_idx == 9'd0 && !tx_valid && !tx_eof && tx_data == 32'd0, "R1",
                {rd_idx, tx_valid, tx_eof, tx_data[20:0]}, 32'd0);
        end else begin
            chk(rd_idx == m_idx,
                m_prev_start ? "R7" : (!m_prev_gate ? "R5" :
                (m_idx == word_count ? "R4" : "R3")),
                {23'd0, rd_idx}, {23'd0, m_idx});
            chk(tx_valid == m_vq, (word_count == 9'd0) ? "R8" : "R5",
                {31'd0, tx_valid}, {31'd0, m_vq});
            chk(tx_eof == m_lq, "R6", {31'd0, tx_eof}, {31'd0, m_lq});
            if (m_vq) chk(tx_data == word_of(m_didx), "R2", tx_data, word_of(m_didx));
            else      chk(tx_data == 32'd0, "R9", tx_data, 32'd0);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; chan_en = 1'b0; tx_rdy = 1'b0;
        period_len = 16'd20; word_count = 9'd5;
        m_tim = '0; m_idx = '0; m_vq = 0; m_lq = 0; m_didx = '0;
        valid_seen = 0;
        @(negedge clk);
        step(1, 0, 0);
        step(1, 1, 1);

        // steady packets, both gates high
        for (int i = 0; i < 60; i++) step(0, 1, 1);

        // zero-length packets: no traffic at all
        word_count = 9'd0;
        valid_seen = 0;
        for (int i = 0; i < 45; i++) step(0, 1, 1);
        chk(valid_seen == 0, "R8", valid_seen, 0);

        // gate drops inside a packet, including on the last word
        period_len = 16'd30; word_count = 9'd8;
        for (int i = 0; i < 40; i++) step(0, (i % 5) != 3, (i % 7) != 6);

        // zero period: every cycle starts a period, never fetches
        period_len = 16'd0;
        valid_seen = 0;
        for (int i = 0; i < 20; i++) step(0, 1, 1);
        chk(valid_seen == 0, "R7", valid_seen, 0);

        // period shorter than packet: start truncates
        period_len = 16'd4; word_count = 9'd10;
        for (int i = 0; i < 30; i++) step(0, 1, 1);

        // mid-run reset
        period_len = 16'd12; word_count = 9'd3;
        for (int i = 0; i < 5; i++) step(0, 1, 1);
        step(1, 1, 1);

        // seeded random run
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 50) == 0) period_len = 16'($urandom % 40);
            if (($urandom % 50) == 0) word_count = 9'($urandom % 21);
            if (($urandom % 400) == 0) step(1, 1, 1);
            else step(0, ($urandom % 8) != 0, ($urandom % 8) != 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule